// File: doc/BRIEF.md
# Framed Six-Channel Serial Transmitter

This block models the output port of a multichannel converter so that system tests have a realistic serial source. After every conversion cycle the surrounding logic presents six 16-bit sample words in parallel, one voltage and one current word for each of three phases, and pulses a start strobe. The block copies the words into a shadow register and then produces one serial frame. A frame consists of a one-period frame sync pulse with the serial clock held quiet, followed by a gated burst of 96 serial clocks that carries the six words.

The serial clock is the system clock divided by `CLK_DIV`, which must be even and at least 2. Each serial period starts with its low half and ends with its high half. Data moves on the falling edge of the serial clock, so a receiver can sample it on the rising edge. The serial clock idles low between frames. While a frame is in progress `busy` is high, and any start strobe seen during that time is discarded. An active-low asynchronous reset returns the block to idle with every output low.

Top module: `sixch_frame_tx`

## Requirements
- R1: `sClk` is low whenever no burst is in progress: in idle, during reset and between frames.
- R2: `fSync` rests low. The system clock edge that accepts a start raises `fSync`, and it stays high for exactly `CLK_DIV` system clocks, which is one serial period.
- R3: `sClk` stays low for every cycle in which `fSync` is high.
- R4: After `fSync` falls, exactly 96 serial periods follow. Each period is `CLK_DIV/2` system clocks with `sClk` low, then `CLK_DIV/2` system clocks with `sClk` high. After the 96th period the block returns to idle.
- R5: Each word is sent as 16 bits, with bit 15 first and bit 0 last.
- R6: Word order on the line is `loadWords[15:0]` (phase 1 voltage), then `[31:16]` (phase 1 current), `[47:32]` (phase 2 voltage), `[63:48]` (phase 2 current), `[79:64]` (phase 3 voltage) and `[95:80]` (phase 3 current).
- R7: `sData` changes only at the start of a serial period. It is steady while `sClk` is high.
- R8: The words are captured on the edge that accepts the start. Later changes on `loadWords` do not alter the frame in progress.
- R9: `busy` is high from the accepting edge until the end of the last serial period. A start sampled while `busy` is high is ignored. A start held high is accepted on the first idle cycle.
- R10: While `rstN` is low, all outputs are low. After reset is released the block is idle.
- R11: `sData` is low outside the 96-period burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start strobe; captures the words and begins a frame when idle |
| loadWords | input | NUM_WORDS*WORD_W | Six sample words; word 0 (phase 1 voltage) is in the lowest bits |
| sClk | output | 1 | Gated serial clock; idles low |
| fSync | output | 1 | Frame sync pulse, one serial period long |
| sData | output | 1 | Serial data, MSB first; changes on falling `sClk` |
| busy | output | 1 | High while a frame is being sent |

## Verification
The hardest cases to reach are the frame boundary and a start that arrives while a frame is running. The first case is a start held high through the final serial period, which must be dropped there and then taken on the very first idle cycle. The second is new words presented at the same time as such a start, which must not leak into the frame in progress. The stimulus raises the start strobe in the middle of a burst while changing the load words, and keeps it high until `busy` is seen low, so a back-to-back frame follows. A reset asserted in the middle of a burst tests recovery. Bit patterns with a single set bit and alternating bits expose errors in the bit order and the word order.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SYNC  = 2'd1,
    ST_SHIFT = 2'd2
  } txState_t;

  // Strobes from the sequencer to the shadow/shift datapath
  typedef struct packed {
    logic capture;  // copy parallel words into the shadow register
    logic shift;    // advance by one bit at a serial period boundary
    logic emit;     // burst active: drive shadow MSB onto the line
  } dpStrobes_t;

endpackage

// File: rtl/sft_rate_div.sv
module sft_rate_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic periodEnd,
  output logic highPhase
);
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF  = CLK_DIV / 2;

  logic [CNT_W-1:0] phaseCnt;

  assign periodEnd = (phaseCnt == CNT_W'(CLK_DIV - 1));
  assign highPhase = (phaseCnt >= CNT_W'(HALF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (!run || periodEnd) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
#(
  parameter int TOTAL_BITS = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       periodEnd,
  input  logic       highPhase,
  output logic       run,
  output dpStrobes_t strobes,
  output logic       sClk,
  output logic       fSync,
  output logic       busy
);
  localparam int BIT_W = $clog2(TOTAL_BITS);

  txState_t         state;
  logic [BIT_W-1:0] bitCnt;
  logic             lastBit;

  assign lastBit = (bitCnt == BIT_W'(TOTAL_BITS - 1));
  assign run     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          bitCnt <= '0;
          if (startReq) state <= ST_SYNC;
        end
        ST_SYNC: begin
          if (periodEnd) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (periodEnd) begin
            if (lastBit) begin
              state  <= ST_IDLE;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.capture = (state == ST_IDLE) && startReq;
    strobes.shift   = (state == ST_SHIFT) && periodEnd;
    strobes.emit    = (state == ST_SHIFT);
  end

  assign sClk  = (state == ST_SHIFT) && highPhase;
  assign fSync = (state == ST_SYNC);
  assign busy  = run;
endmodule

// File: rtl/sft_datapath.sv
module sft_datapath
  import sft_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_WORDS*WORD_W-1:0]   loadWords,
  input  dpStrobes_t                    strobes,
  output logic                          sData
);
  localparam int FRAME_W = NUM_WORDS * WORD_W;

  logic [FRAME_W-1:0] loadImage;
  logic [FRAME_W-1:0] shadow;

  // Word 0 goes to the top of the shadow so that it leaves first
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_order
    assign loadImage[FRAME_W-1-w*WORD_W -: WORD_W] = loadWords[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (strobes.capture) begin
      shadow <= loadImage;
    end else if (strobes.shift) begin
      shadow <= {shadow[FRAME_W-2:0], 1'b0};
    end
  end

  assign sData = strobes.emit & shadow[FRAME_W-1];
endmodule

// File: rtl/sixch_frame_tx.sv
module sixch_frame_tx
  import sft_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 6,
  parameter int CLK_DIV   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startReq,
  input  logic [NUM_WORDS*WORD_W-1:0] loadWords,
  output logic                        sClk,
  output logic                        fSync,
  output logic                        sData,
  output logic                        busy
);
  localparam int TOTAL_BITS = NUM_WORDS * WORD_W;

  logic       run;
  logic       periodEnd;
  logic       highPhase;
  dpStrobes_t strobes;

  sft_rate_div #(.CLK_DIV(CLK_DIV)) u_rate_div (
    .clk       (clk),
    .rstN      (rstN),
    .run       (run),
    .periodEnd (periodEnd),
    .highPhase (highPhase)
  );

  sft_ctrl #(.TOTAL_BITS(TOTAL_BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .periodEnd (periodEnd),
    .highPhase (highPhase),
    .run       (run),
    .strobes   (strobes),
    .sClk      (sClk),
    .fSync     (fSync),
    .busy      (busy)
  );

  sft_datapath #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .loadWords (loadWords),
    .strobes   (strobes),
    .sData     (sData)
  );
endmodule

// File: rtl/sft_checker.sv
module sft_checker #(
  parameter int CLK_DIV    = 4,
  parameter int TOTAL_BITS = 96
) (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic sClk,
  input logic fSync,
  input logic sData,
  input logic busy
);
  logic [15:0] syncLen;
  logic [15:0] edgeCnt;
  logic        sClkD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncLen <= '0;
      edgeCnt <= '0;
      sClkD   <= 1'b0;
    end else begin
      sClkD   <= sClk;
      syncLen <= fSync ? syncLen + 1'b1 : 16'd0;
      if (fSync)              edgeCnt <= '0;
      else if (sClk && !sClkD) edgeCnt <= edgeCnt + 1'b1;
    end
  end

  a_r1_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sClk);

  a_r2_sync_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> fSync);

  a_r2_sync_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fSync) |-> (syncLen == 16'(CLK_DIV)));

  a_r3_quiet_in_sync: assert property (@(posedge clk) disable iff (!rstN)
    fSync |-> !sClk);

  a_r4_burst_count: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (edgeCnt == 16'(TOTAL_BITS)));

  a_r7_data_held_high: assert property (@(posedge clk) disable iff (!rstN)
    sClk |-> $stable(sData));

  a_r11_data_low_outside: assert property (@(posedge clk) disable iff (!rstN)
    (!busy || fSync) |-> !sData);

  a_r9_ignore_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> !$rose(fSync));
endmodule

bind sixch_frame_tx sft_checker #(
  .CLK_DIV    (CLK_DIV),
  .TOTAL_BITS (NUM_WORDS * WORD_W)
) u_sft_checker (
  .clk      (clk),
  .rstN     (rstN),
  .startReq (startReq),
  .sClk     (sClk),
  .fSync    (fSync),
  .sData    (sData),
  .busy     (busy)
);

// File: tb/test_sixch_frame_tx.sv
`timescale 1ns/1ps
module test_sixch_frame_tx;
  localparam int WW    = 16;
  localparam int NW    = 6;
  localparam int DIV   = 4;
  localparam int NBITS = NW * WW;
  localparam int TOTAL = DIV + NBITS * DIV;

  logic            clk = 1'b0;
  logic            rstN;
  logic            startReq;
  logic [NW*WW-1:0] loadWords;
  logic            sClk, fSync, sData, busy;

  always #2 clk = ~clk;  // 250 MHz

  sixch_frame_tx #(.WORD_W(WW), .NUM_WORDS(NW), .CLK_DIV(DIV)) i_sixch_frame_tx (
    .clk(clk), .rstN(rstN), .startReq(startReq), .loadWords(loadWords),
    .sClk(sClk), .fSync(fSync), .sData(sData), .busy(busy)
  );

  int nCmp = 0;
  int nBad = 0;

  // Behavioural reference: cycle count since the accepting edge
  bit          refActive = 0;
  int          refCycle  = 0;
  logic [15:0] refWords[NW];

  always @(posedge clk) begin
    if (!rstN) begin
      refActive = 0;
    end else if (refActive) begin
      refCycle++;
      if (refCycle == TOTAL) refActive = 0;
    end else if (startReq) begin
      refActive = 1;
      refCycle  = 0;
      for (int i = 0; i < NW; i++) refWords[i] = loadWords[i*WW +: WW];  // R8 capture
    end
  end

  task automatic report(input string req, input string sig, input logic act, input logic exp);
    nBad++;
    $display("FAIL %s %s at %0t: actual %0b expected %0b", req, sig, $time, act, exp);
  endtask

  int   rises = 0;
  logic prevC = 0, prevB = 0;

  always @(negedge clk) begin
    logic eF, eC, eD, eB;
    #1;
    eF = 0; eC = 0; eD = 0; eB = 0;
    if (rstN && refActive) begin
      eB = 1;
      if (refCycle < DIV) begin
        eF = 1;
      end else begin
        int k, b;
        k  = refCycle - DIV;
        b  = k / DIV;
        eC = (k % DIV) >= DIV / 2;
        eD = refWords[b / WW][WW - 1 - (b % WW)];  // R5 MSB first, R6 word order
      end
    end
    nCmp++;
    if (fSync !== eF || sClk !== eC || sData !== eD || busy !== eB) begin
      if (!rstN) report("R10", "reset outputs", {fSync, sClk, sData, busy} != 0, 1'b0);
      if (fSync !== eF) report("R2", "fSync", fSync, eF);
      if (sClk  !== eC) report(eF ? "R3" : (eB ? "R4" : "R1"), "sClk", sClk, eC);
      if (sData !== eD) report(eB ? "R5 R6 R7 R8" : "R11", "sData", sData, eD);
      if (busy  !== eB) report("R9", "busy", busy, eB);
    end
    // R4: count rising serial edges per frame
    if (!rstN || fSync) rises = 0;
    else if (sClk && !prevC) rises++;
    if (rstN && prevB && !busy) begin
      nCmp++;
      if (rises != NBITS) begin
        nBad++;
        $display("FAIL R4 burst edges: actual %0d expected %0d", rises, NBITS);
      end
    end
    prevC = sClk;
    prevB = rstN ? busy : 1'b0;
  end

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
  endtask

  initial begin
    #500000;
    nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; startReq = 1'b0; loadWords = '0;
    repeat (4) @(negedge clk);          // R10 checked during reset
    rstN = 1'b1;
    repeat (5) @(negedge clk);          // R1 idle

    // Distinct words
    loadWords = {16'h0F0F, 16'hC3A5, 16'h7E81, 16'h1234, 16'hFFFF, 16'h8001};
    pulseStart();
    repeat (60) @(negedge clk);
    // R8, R9: new words and a start while busy; start held into idle for back-to-back
    loadWords = {16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555};
    startReq  = 1'b1;
    waitIdle();
    @(negedge clk) startReq = 1'b0;
    waitIdle();
    repeat (7) @(negedge clk);

    // R5: single set bits expose bit order
    loadWords = {16'h0001, 16'h8000, 16'h0002, 16'h4000, 16'h0100, 16'h0080};
    pulseStart();
    waitIdle();
    repeat (3) @(negedge clk);

    // Mid-frame reset, then recovery (R10)
    loadWords = {6{16'hFFFF}};
    pulseStart();
    repeat (150) @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    loadWords = {16'h6B2D, 16'h0000, 16'hDEAD, 16'hBEEF, 16'h0000, 16'h13C7};
    pulseStart();
    waitIdle();
    repeat (10) @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule